// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Unit

This unit sits beside the transmit and receive byte queues of a serial peripheral. It keeps a fill counter for each queue from the push and pop strobes that the queues already generate. It clears either counter when software asks for it. It raises a maskable, level-sensitive interrupt from three sources: the receive queue nearing full, the transmit queue nearing empty, and the end of a transfer. The serial engine and the clock generation sit outside this block. The end-of-transfer pulse reaches it as an input.

Software sees four 32-bit registers behind a simple write-strobe and read-address port, selected by a 2-bit word index. Index 0 is a control register whose only bits are the two queue-clear bits. Index 1 enables interrupt sources. Index 2 holds the pending flags, and writing a one to a flag clears it. Index 3 reports both fill levels in one word. The usual flow is to service the queue that raised a flag, then clear the flag. A flag whose condition still holds comes back at once.

Top module: `spi_fifo_irq`

## Requirements
- R1: While `rst` is high, `irq` and `cfg_rdata` are 0. On release, every fill level, every enable bit and every pending flag starts from 0.
- R2: A push with no pop adds one to a queue's level. A pop with no push subtracts one. A push and a pop in the same cycle leave the level unchanged. Index 3 returns the receive level in bits [6:0] and the transmit level in bits [22:16].
- R3: A push when the level is already DEPTH (64) has no effect, and neither does a pop when the level is 0.
- R4: A write to index 0 with bit 8 set clears the transmit level to 0 at that clock edge. Bit 9 does the same for the receive level. The clear wins over a push in the same cycle. Index 0 always reads 0.
- R5: Pending bit 4 (receive high) becomes set one cycle after the receive level is at or above 3*DEPTH/4 (48).
- R6: Pending bit 12 (transmit low) becomes set one cycle after the transmit level is at or below DEPTH/4 (16).
- R7: A pulse on `xfer_done` sets pending bit 16. When the pulse and a write-one-to-clear of that bit fall in the same cycle, the bit ends up set.
- R8: Writing ones to index 2 clears the matching pending bits, and writing zeros leaves them alone. A level flag whose condition is still true is clear for one cycle and is set again in the cycle after.
- R9: Index 1 stores only bits 4, 12 and 16. `irq` is high one cycle after any pending bit is set together with its enable bit, and low one cycle after there is none.
- R10: A pending bit stays set after its source condition goes away, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Byte written into transmit queue |
| tx_pop | input | 1 | Byte taken from transmit queue |
| rx_push | input | 1 | Byte written into receive queue |
| rx_pop | input | 1 | Byte taken from receive queue |
| xfer_done | input | 1 | One-cycle end-of-transfer pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
A level counter that drifts by even one byte shows up at index 3 on the next read. Near a threshold, it also moves pending bit 4 or 12 a cycle early or late. A wrong pending flag reaches `irq` one cycle later and shows in the index 2 read one cycle after its address is presented. Cases where a clear competes with an event (queue clear with a push, flag clear with a completion pulse or with a condition that still holds) are driven in the same cycle. The outcome is read back a few cycles later, so an ordering fault leaves a wrong value behind.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;
  localparam int REG_W = 32;

  // register word indices
  localparam logic [1:0] IDX_CTRL  = 2'd0;
  localparam logic [1:0] IDX_EN    = 2'd1;
  localparam logic [1:0] IDX_PEND  = 2'd2;
  localparam logic [1:0] IDX_LEVEL = 2'd3;

  // control bits
  localparam int CTRL_TX_CLR = 8;
  localparam int CTRL_RX_CLR = 9;

  // shared enable / pending bit positions
  localparam int SRC_RX_HI = 4;
  localparam int SRC_TX_LO = 12;
  localparam int SRC_DONE  = 16;

  // level word field offsets
  localparam int LVL_RX_LSB = 0;
  localparam int LVL_TX_LSB = 16;

  // internal source index order
  typedef enum logic [1:0] {
    S_RXHI = 2'd0,
    S_TXLO = 2'd1,
    S_DONE = 2'd2
  } src_e;
  localparam int NSRC = 3;
endpackage

// File: rtl/fil_level_cnt.sv
module fil_level_cnt #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] level
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic          is_full, is_empty, inc, dec;
  logic [CW-1:0] cnt_q;

  assign is_full  = (cnt_q == FULL_LVL);
  assign is_empty = (cnt_q == '0);
  assign inc      = push && !is_full;
  assign dec      = pop && !is_empty;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && !dec) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec && !inc) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign level = cnt_q;

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_LVL);

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0));

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !clr && cnt_q < FULL_LVL) |=> (level == $past(level) + 1'b1));

  // R2
  balanced_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !clr && cnt_q != '0 && cnt_q != FULL_LVL) |=> $stable(level));
endmodule

// File: rtl/fil_irq_status.sv
module fil_irq_status
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int RX_HI_LVL = (DEPTH * 3) / 4,
  localparam int TX_LO_LVL = DEPTH / 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   rx_level,
  input  logic [CW-1:0]   tx_level,
  input  logic            done,
  input  logic [NSRC-1:0] w1c,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] pend,
  output logic            irq
);
  logic [NSRC-1:0] cond, pend_q, pend_d;
  logic            irq_q;

  assign cond[S_RXHI] = (rx_level >= CW'(RX_HI_LVL));
  assign cond[S_TXLO] = (tx_level <= CW'(TX_LO_LVL));
  assign cond[S_DONE] = done;

  // level sources: clear wins for one cycle; event source: new pulse wins
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == S_DONE) begin : g_evt
      assign pend_d[g] = cond[g] | (pend_q[g] & ~w1c[g]);
    end else begin : g_lvl
      assign pend_d[g] = w1c[g] ? 1'b0 : (pend_q[g] | cond[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= |(pend_q & en);
    end
  end

  assign pend = pend_q;
  assign irq  = irq_q;

  // R5
  rx_hi_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_level >= CW'(RX_HI_LVL) && !w1c[S_RXHI]) |=> pend[S_RXHI]);

  // R6
  tx_lo_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= CW'(TX_LO_LVL) && !w1c[S_TXLO]) |=> pend[S_TXLO]);

  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> pend[S_DONE]);

  // R8
  lvl_clear_chk: assert property (@(posedge clk) disable iff (rst)
    w1c[S_TXLO] |=> !pend[S_TXLO]);

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend[S_RXHI] && !w1c[S_RXHI]) |=> pend[S_RXHI]);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pend & en)) |=> irq);

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(pend & en)) |=> !irq);
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_push,
  input  logic             tx_pop,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             xfer_done,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             irq
);
  logic            wr_ctrl, wr_en, wr_pend;
  logic            tx_clr, rx_clr;
  logic [CW-1:0]   tx_lvl, rx_lvl;
  logic [NSRC-1:0] en_q, pend, w1c;
  logic [REG_W-1:0] en_word, pend_word, lvl_word, rd_mux, rdata_q;

  assign wr_ctrl = cfg_we && (cfg_addr == IDX_CTRL);
  assign wr_en   = cfg_we && (cfg_addr == IDX_EN);
  assign wr_pend = cfg_we && (cfg_addr == IDX_PEND);

  // queue clear bits act only in the write cycle and are never stored
  assign tx_clr = wr_ctrl && cfg_wdata[CTRL_TX_CLR];
  assign rx_clr = wr_ctrl && cfg_wdata[CTRL_RX_CLR];

  assign w1c[S_RXHI] = wr_pend && cfg_wdata[SRC_RX_HI];
  assign w1c[S_TXLO] = wr_pend && cfg_wdata[SRC_TX_LO];
  assign w1c[S_DONE] = wr_pend && cfg_wdata[SRC_DONE];

  fil_level_cnt #(.DEPTH(DEPTH)) u_tx_lvl (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(tx_push), .pop(tx_pop), .level(tx_lvl)
  );

  fil_level_cnt #(.DEPTH(DEPTH)) u_rx_lvl (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(rx_push), .pop(rx_pop), .level(rx_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr_en) begin
      en_q[S_RXHI] <= cfg_wdata[SRC_RX_HI];
      en_q[S_TXLO] <= cfg_wdata[SRC_TX_LO];
      en_q[S_DONE] <= cfg_wdata[SRC_DONE];
    end
  end

  fil_irq_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst(rst),
    .rx_level(rx_lvl), .tx_level(tx_lvl),
    .done(xfer_done), .w1c(w1c), .en(en_q),
    .pend(pend), .irq(irq)
  );

  always_comb begin
    en_word   = '0;
    pend_word = '0;
    lvl_word  = '0;
    en_word[SRC_RX_HI]   = en_q[S_RXHI];
    en_word[SRC_TX_LO]   = en_q[S_TXLO];
    en_word[SRC_DONE]    = en_q[S_DONE];
    pend_word[SRC_RX_HI] = pend[S_RXHI];
    pend_word[SRC_TX_LO] = pend[S_TXLO];
    pend_word[SRC_DONE]  = pend[S_DONE];
    lvl_word[LVL_RX_LSB +: CW] = rx_lvl;
    lvl_word[LVL_TX_LSB +: CW] = tx_lvl;
    case (cfg_addr)
      IDX_EN:    rd_mux = en_word;
      IDX_PEND:  rd_mux = pend_word;
      IDX_LEVEL: rd_mux = lvl_word;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign cfg_rdata = rdata_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (cfg_rdata == '0 && !irq));

  // R4
  ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr == IDX_CTRL) |=> (cfg_rdata == '0));
endmodule

// File: tb/tb_spi_fifo_irq.sv
module tb_spi_fifo_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, xfer_done = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_fifo_irq dut (
    .clk(clk), .rst(rst), .tx_push(tx_push), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_pop(rx_pop), .xfer_done(xfer_done),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq)
  );

  localparam logic [2:0] OP_WR = 0, OP_RD = 1, OP_IRQ = 2, OP_PRX = 3,
                         OP_QRX = 4, OP_PTX = 5, OP_QTX = 6, OP_DONE = 7;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  idx;
    logic [31:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,   2'd3, 32'h0,        4'd2},  // R2 empty levels
    '{OP_RD,   2'd2, 32'h1000,     4'd6},  // R6 tx level 0 <= 16
    '{OP_IRQ,  2'd0, 32'h0,        4'd9},  // R9 masked
    '{OP_WR,   2'd1, 32'hFFFFFFFF, 4'd9},
    '{OP_RD,   2'd1, 32'h11010,    4'd9},  // R9 only three bits kept
    '{OP_IRQ,  2'd0, 32'h1,        4'd9},  // R9
    '{OP_PTX,  2'd0, 32'd20,       4'd2},
    '{OP_RD,   2'd3, 32'h140000,   4'd2},  // R2 tx level 20
    '{OP_WR,   2'd2, 32'h1000,     4'd8},
    '{OP_RD,   2'd2, 32'h0,        4'd8},  // R8 cleared
    '{OP_IRQ,  2'd0, 32'h0,        4'd9},  // R9
    '{OP_QTX,  2'd0, 32'd4,        4'd6},
    '{OP_RD,   2'd2, 32'h1000,     4'd6},  // R6 level 16
    '{OP_PTX,  2'd0, 32'd10,       4'd10},
    '{OP_RD,   2'd2, 32'h1000,     4'd10}, // R10 sticky
    '{OP_PRX,  2'd0, 32'd47,       4'd5},
    '{OP_RD,   2'd2, 32'h1000,     4'd5},  // R5 47 below
    '{OP_PRX,  2'd0, 32'd1,        4'd5},
    '{OP_RD,   2'd2, 32'h1010,     4'd5},  // R5 48 reached
    '{OP_WR,   2'd2, 32'h10,       4'd8},
    '{OP_RD,   2'd2, 32'h1010,     4'd8},  // R8 re-sets
    '{OP_WR,   2'd2, 32'h0,        4'd8},
    '{OP_RD,   2'd2, 32'h1010,     4'd8},  // R8 zeros ignored
    '{OP_PRX,  2'd0, 32'd30,       4'd3},
    '{OP_RD,   2'd3, 32'h1A0040,   4'd3},  // R3 saturate 64
    '{OP_WR,   2'd0, 32'h200,      4'd4},
    '{OP_RD,   2'd3, 32'h1A0000,   4'd4},  // R4 rx cleared
    '{OP_RD,   2'd0, 32'h0,        4'd4},  // R4 ctrl reads 0
    '{OP_WR,   2'd2, 32'hFFFFFFFF, 4'd8},
    '{OP_RD,   2'd2, 32'h0,        4'd8},  // R8 all cleared
    '{OP_DONE, 2'd0, 32'h0,        4'd7},
    '{OP_RD,   2'd2, 32'h10000,    4'd7},  // R7
    '{OP_IRQ,  2'd0, 32'h1,        4'd9}   // R9
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_wdata = 0;
    idle(2);
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    check(tag, cfg_rdata, exp);
  endtask

  task automatic strobe(input logic [2:0] op, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_push = (op == OP_PRX); rx_pop = (op == OP_QRX);
      tx_push = (op == OP_PTX); tx_pop = (op == OP_QTX);
      xfer_done = (op == OP_DONE);
    end
    @(negedge clk);
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; xfer_done = 0;
    idle(2);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    check("R1 rdata in reset", cfg_rdata, 32'h0);
    rst = 0;
    idle(2);

    for (int k = 0; k < NV; k++) begin
      string tg;
      tg = $sformatf("R%0d vec %0d", VEC[k].req, k);
      case (VEC[k].op)
        OP_WR:   wr(VEC[k].idx, VEC[k].val);
        OP_RD:   rd(VEC[k].idx, tg, VEC[k].val);
        OP_IRQ:  begin @(negedge clk); check(tg, {31'b0, irq}, VEC[k].val); end
        OP_DONE: strobe(OP_DONE, 1);
        default: strobe(VEC[k].op, int'(VEC[k].val));
      endcase
    end

    // R9 disabling the completion source drops irq
    wr(2'd1, 32'h1010);
    @(negedge clk); check("R9 masked done", {31'b0, irq}, 32'h0);

    // R4 tx clear -> level 0
    wr(2'd0, 32'h100);
    rd(2'd3, "R4 tx cleared", 32'h0);

    // R3 pop when empty ignored
    strobe(OP_QTX, 3);
    rd(2'd3, "R3 pop empty", 32'h0);

    // R2 simultaneous push and pop
    strobe(OP_PRX, 5);
    @(negedge clk); rx_push = 1; rx_pop = 1;
    idle(3);
    rx_push = 0; rx_pop = 0;
    idle(2);
    rd(2'd3, "R2 push+pop same cycle", 32'h5);

    // R4 clear wins over same-cycle push
    @(negedge clk);
    cfg_we = 1; cfg_addr = 2'd0; cfg_wdata = 32'h200; rx_push = 1;
    @(negedge clk);
    cfg_we = 0; cfg_wdata = 0; rx_push = 0;
    idle(2);
    rd(2'd3, "R4 clear over push", 32'h0);

    // R7 completion pulse and its clear in the same cycle
    wr(2'd2, 32'hFFFFFFFF);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 2'd2; cfg_wdata = 32'h10000; xfer_done = 1;
    @(negedge clk);
    cfg_we = 0; cfg_wdata = 0; xfer_done = 0;
    idle(2);
    rd(2'd2, "R7 set beats clear", 32'h11000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule